// File: doc/BRIEF.md
# Configurable SRAM Read Output Stage

This block is the last stage of a synchronous memory's read path, between the array's read data and the bidirectional data pins. It takes read and deselect command strobes that the input registers have already captured. It decides in which cycle the read data reaches the pins, and in which cycle the pin drivers let go of the bus. The block returns the data word together with a per-bit drive enable, which the pad ring uses to steer its tri-state buffers.

Two static configuration pins set the timing. The read mode pin chooses between a flow-through path and a pipelined path. The flow-through path gives a 2-1-1-1 burst pattern, and the pipelined path, which has one rising-edge output register, gives a 3-1-1-1 pattern. The deselect mode pin chooses whether a deselect turns the drivers off at once (single-cycle) or one clock later (dual-cycle). With both pins low the block runs in its power-on arrangement: pipelined reads with single-cycle deselect. An output enable input gates the drivers combinationally.

Between commands the bus keeps showing the last read word. In flow-through mode with dual-cycle deselect, a read can reach the bus in the same cycle as an earlier deselect. In pipelined mode with single-cycle deselect, a deselect can take effect in the same cycle as an earlier read. In both cases the newer command decides the bus state.

Top module: `sram_rd_out_stage`

## Requirements
- R1: After a synchronous active-low reset, with no command given, every bit of `dq_drv_en` is 0.
- R2: With `cfg_flow`=0 (pipelined), a read strobed in cycle N drives `dq_out` with the `arr_rdata` value of cycle N during cycle N+1.
- R3: With `cfg_flow`=1 (flow-through), a read strobed in cycle N drives `dq_out` with the `arr_rdata` value of that same cycle N.
- R4: In cycles with no read taking effect and no deselect taking effect, the bus keeps its previous drive state, and while driven it keeps the last read word.
- R5: With `cfg_dual`=0 (single-cycle deselect), the drive enables are 0 in the cycle the deselect strobe is high, and they stay 0 until a later read takes effect.
- R6: With `cfg_dual`=1 (dual-cycle deselect), the bus keeps its state during the cycle of the deselect strobe and is released from the following cycle on.
- R7: When a read and a deselect from different cycles take effect in the same cycle, the newer command wins. Pipelined reads with single-cycle deselect give an undriven bus. Flow-through reads with dual-cycle deselect give a driven bus that carries the new read word.
- R8: When `rd_cmd` and `dsel_cmd` are high in the same cycle, the strobe is treated as a deselect alone.
- R9: While `out_en` is 0, `dq_drv_en` is 0 in that same cycle, whatever the internal state is.
- R10: All bits of `dq_drv_en` carry the same value in every cycle.
- R11: With `cfg_flow`=0 and `cfg_dual`=0, the block shows the pipelined read timing of R2 and the single-cycle deselect timing of R5.
- R12: After back-to-back reads and a deselect, `dq_drv_en` stays 0 in every cycle from the turn-off cycle until the next read takes effect, so a second bus driver can use those cycles without contention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_flow | input | 1 | Read mode: 1 = flow-through, 0 = pipelined (static) |
| cfg_dual | input | 1 | Deselect mode: 1 = dual-cycle, 0 = single-cycle (static) |
| rd_cmd | input | 1 | Registered read strobe; array data for it is valid in the same cycle |
| dsel_cmd | input | 1 | Registered deselect strobe |
| arr_rdata | input | DATA_W | Read data from the array |
| out_en | input | 1 | Output enable, active high, acts combinationally |
| dq_out | output | DATA_W | Data toward the pin drivers |
| dq_drv_en | output | DATA_W | Per-bit drive enable for the pin drivers |

## Verification
The embedded properties are checked on every clock. They cover the one-cycle read latency of the pipelined path and the zero-cycle latency of the flow-through path. They also cover the release in the same cycle for single-cycle deselect, the release one cycle later for dual-cycle deselect, the combinational gating by output enable, the uniform per-bit enables, and the stable pipelined word between reads. Three things can only be shown by the bench's command sequences in all four mode combinations, checked against an arithmetic schedule of when each command takes effect: which command wins when two take effect together, the word held over long idle stretches, and the contention-free gap after a burst.

// File: rtl/sram_rdo_pkg.sv
`timescale 1ns/1ps
// Shared types of the SRAM read output stage.
// Assumes: both mode encodings are chosen so that all-low pins mean
// pipelined reads with single-cycle deselect.
package sram_rdo_pkg;

    typedef enum logic {
        RD_PIPELINED = 1'b0,
        RD_FLOWTHRU  = 1'b1
    } rd_mode_e;

    typedef enum logic {
        DS_SINGLE = 1'b0,
        DS_DUAL   = 1'b1
    } ds_mode_e;

    // Events that take effect on the bus in the current cycle.
    typedef struct packed {
        logic read;
        logic desel;
    } stage_evt_t;

endpackage

// File: rtl/sram_rdo_cmd_stage.sv
`timescale 1ns/1ps
// Command timing stage: accepts the read and deselect strobes and aligns
// each one to the cycle in which it acts on the bus. A read acts at once in
// flow-through mode and one cycle later in pipelined mode. A deselect acts
// at once in single-cycle mode and one cycle later in dual-cycle mode.
// Assumes: strobes come from input registers; mode pins are static.
module sram_rdo_cmd_stage
    import sram_rdo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rd_mode_e   rd_mode,
    input  ds_mode_e   ds_mode,
    input  logic       rd_cmd,
    input  logic       dsel_cmd,
    output logic       rd_acc,
    output stage_evt_t evt
);

    logic rd_dly_q;
    logic ds_dly_q;

    // A deselect in the same cycle as a read suppresses the read.
    always_comb begin
        rd_acc = rd_cmd & ~dsel_cmd;
    end

    // One-stage delay line for both strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_dly_q <= 1'b0;
            ds_dly_q <= 1'b0;
        end else begin
            rd_dly_q <= rd_acc;
            ds_dly_q <= dsel_cmd;
        end
    end

    // Pick, per mode, the tap at which each strobe acts.
    always_comb begin
        evt.read  = (rd_mode == RD_FLOWTHRU) ? rd_acc : rd_dly_q;
        evt.desel = (ds_mode == DS_DUAL)     ? ds_dly_q : dsel_cmd;
    end

endmodule

// File: rtl/sram_rdo_drive_ctrl.sv
`timescale 1ns/1ps
// Drive state: decides whether the bus is owned in the current cycle.
// A read taking effect claims the bus and a deselect taking effect releases
// it. With neither, the previous state holds. If both act in one cycle they
// come from different commands, and the newer one wins: that is the read
// under dual-cycle deselect and the deselect under single-cycle deselect.
// Assumes: events come from sram_rdo_cmd_stage.
module sram_rdo_drive_ctrl
    import sram_rdo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ds_mode_e   ds_mode,
    input  stage_evt_t evt,
    output logic       drv_valid
);

    logic own_q;

    // Resolve this cycle's ownership from the events and the held state.
    always_comb begin
        if (evt.read && evt.desel) begin
            drv_valid = (ds_mode == DS_DUAL);
        end else if (evt.read) begin
            drv_valid = 1'b1;
        end else if (evt.desel) begin
            drv_valid = 1'b0;
        end else begin
            drv_valid = own_q;
        end
    end

    // Carry ownership into the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= 1'b0;
        end else begin
            own_q <= drv_valid;
        end
    end

endmodule

// File: rtl/sram_rdo_data_stage.sv
`timescale 1ns/1ps
// Data path: one rising-edge output register that loads on every accepted
// read. In pipelined mode the register drives the output. In flow-through
// mode the array word bypasses it in a read cycle and the register supplies
// the held word otherwise.
// Assumes: arr_rdata is valid in the cycle of the read strobe.
module sram_rdo_data_stage
    import sram_rdo_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rd_mode_e          rd_mode,
    input  logic              rd_acc,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] data_out
);

    logic [DATA_W-1:0] word_q;

    // Output register: capture the array word of each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (rd_acc) begin
            word_q <= arr_rdata;
        end
    end

    // Bypass or registered path, chosen by the read mode.
    always_comb begin
        if (rd_mode == RD_FLOWTHRU && rd_acc) begin
            data_out = arr_rdata;
        end else begin
            data_out = word_q;
        end
    end

    // R4: between pipelined reads the output word does not move.
    p_hold_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == RD_PIPELINED && !rd_acc) |=> $stable(data_out));

endmodule

// File: rtl/sram_rdo_pad_bit.sv
`timescale 1ns/1ps
// One data lane toward the pad: the data bit passes through, and the drive
// enable combines bus ownership with the output enable.
// Assumes: out_en is combinational and needs no synchronising.
module sram_rdo_pad_bit (
    input  logic data_bit,
    input  logic drv_valid,
    input  logic out_en,
    output logic pad_d,
    output logic pad_en
);

    // Lane gating.
    always_comb begin
        pad_d  = data_bit;
        pad_en = drv_valid & out_en;
    end

endmodule

// File: rtl/sram_rd_out_stage.sv
`timescale 1ns/1ps
// Top of the SRAM read output stage. It aligns the commands, tracks bus
// ownership, holds or bypasses the read word, and fans out to one pad lane
// per data bit.
// Assumes: cfg_flow and cfg_dual are held static while out of reset.
module sram_rd_out_stage #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_flow,
    input  logic              cfg_dual,
    input  logic              rd_cmd,
    input  logic              dsel_cmd,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              out_en,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_drv_en
);
    import sram_rdo_pkg::*;

    localparam logic [DATA_W-1:0] LANES_ON  = '1;
    localparam logic [DATA_W-1:0] LANES_OFF = '0;

    rd_mode_e          rd_mode;
    ds_mode_e          ds_mode;
    logic              rd_acc;
    stage_evt_t        evt;
    logic              drv_valid;
    logic [DATA_W-1:0] data_word;

    // Map the configuration pins onto mode types.
    always_comb begin
        rd_mode = rd_mode_e'(cfg_flow);
        ds_mode = ds_mode_e'(cfg_dual);
    end

    sram_rdo_cmd_stage u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_mode  (rd_mode),
        .ds_mode  (ds_mode),
        .rd_cmd   (rd_cmd),
        .dsel_cmd (dsel_cmd),
        .rd_acc   (rd_acc),
        .evt      (evt)
    );

    sram_rdo_drive_ctrl u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .ds_mode   (ds_mode),
        .evt       (evt),
        .drv_valid (drv_valid)
    );

    sram_rdo_data_stage #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_mode   (rd_mode),
        .rd_acc    (rd_acc),
        .arr_rdata (arr_rdata),
        .data_out  (data_word)
    );

    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
        sram_rdo_pad_bit u_lane (
            .data_bit  (data_word[b]),
            .drv_valid (drv_valid),
            .out_en    (out_en),
            .pad_d     (dq_out[b]),
            .pad_en    (dq_drv_en[b])
        );
    end

    // R3: a flow-through read is on the bus in its own cycle.
    p_flow_same_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flow && rd_cmd && !dsel_cmd) |-> (drv_valid && dq_out == arr_rdata));

    // R2: a pipelined read shows its word one cycle later, unless a
    // single-cycle deselect in that cycle takes the bus first (R7).
    p_pipe_next_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_flow && rd_cmd && !dsel_cmd) |=>
            (dq_out == $past(arr_rdata) && (drv_valid || (dsel_cmd && !cfg_dual))));

    // R5: a single-cycle deselect releases the bus in its own cycle.
    p_single_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dual && dsel_cmd) |-> (dq_drv_en == LANES_OFF));

    // R6: a dual-cycle deselect releases the bus in the next cycle, unless a
    // flow-through read in that cycle takes it back.
    p_dual_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dual && dsel_cmd) |=> (!drv_valid || (cfg_flow && rd_cmd && !dsel_cmd)));

    // R9: with output enable low, no lane drives.
    p_oe_gates_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (dq_drv_en == LANES_OFF));

    // R10: all lanes agree.
    p_lanes_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_drv_en == LANES_OFF) || (dq_drv_en == LANES_ON));

endmodule

// File: tb/sram_rd_out_stage_tb_top.sv
`timescale 1ns/1ps
// Bench: runs three command scenarios in each of the four mode combinations.
// The expected bus state comes from an arithmetic schedule: each command
// takes effect at its cycle plus its mode delay, and the newest command in
// effect decides the bus.
module sram_rd_out_stage_tb_top;

    localparam int W  = 18;
    localparam int NC = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_flow = 1'b0;
    logic         cfg_dual = 1'b0;
    logic         rd_cmd = 1'b0;
    logic         dsel_cmd = 1'b0;
    logic [W-1:0] arr_rdata = '0;
    logic         out_en = 1'b0;
    logic [W-1:0] dq_out;
    logic [W-1:0] dq_drv_en;

    always #10 clk = ~clk;

    sram_rd_out_stage #(.DATA_W(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_flow  (cfg_flow),
        .cfg_dual  (cfg_dual),
        .rd_cmd    (rd_cmd),
        .dsel_cmd  (dsel_cmd),
        .arr_rdata (arr_rdata),
        .out_en    (out_en),
        .dq_out    (dq_out),
        .dq_drv_en (dq_drv_en)
    );

    int           n_vec = 0;
    int           n_bad = 0;
    bit           done  = 1'b0;
    int           cmd [NC];      // 0 idle, 1 read, 2 deselect, 3 both
    logic [W-1:0] dat [NC];
    bit           oeb [NC];
    int           sid;
    bit           flow;
    bit           dual;
    logic [31:0]  lfsr = 32'h1D2C_3B4A;

    function automatic logic [31:0] step_lfsr(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (mode flow=%0d dual=%0d scn %0d): actual %h expected %h",
                     tag, flow, dual, sid, act, exp);
        end
    endtask

    // Schedule model: the newest command in effect at cycle t owns the bus.
    function automatic void expect_at(input int t, output bit drv,
                                      output logic [W-1:0] word, output string tag);
        int be = -1;
        int bc = -1;
        bit bk = 1'b0;
        bit tie = 1'b0;
        for (int c = 0; c <= t; c++) begin
            bit is_rd;
            int e;
            if (cmd[c] == 0) continue;
            is_rd = (cmd[c] == 1);
            e = c + (is_rd ? (flow ? 0 : 1) : (dual ? 1 : 0));
            if (e > t) continue;
            if (e > be || (e == be && c > bc)) begin
                tie = (e == be);
                be = e;
                bc = c;
                bk = is_rd;
            end
        end
        drv  = (be >= 0) && bk;
        word = (bc >= 0) ? dat[bc] : '0;
        if (!oeb[t])              tag = "R9";
        else if (cmd[t] == 3)     tag = "R8";
        else if (tie && be == t)  tag = "R7";
        else if (be < 0)          tag = "R1";
        else if (!bk)             tag = (sid == 0) ? "R12" : (dual ? "R6" : "R5");
        else if (be == t)         tag = flow ? "R3" : "R2";
        else                      tag = "R4";
        if (!flow && !dual) tag = {"R11/", tag};
    endfunction

    task automatic build(input int s);
        for (int t = 0; t < NC; t++) begin
            lfsr = step_lfsr(lfsr);
            dat[t] = lfsr[W-1:0];
            oeb[t] = 1'b1;
            cmd[t] = 0;
            if (s == 0) begin
                if (t < 4 || t == 10 || t == 13 || t == 17 || t == 18) cmd[t] = 1;
                if (t == 4 || t == 12 || t == 19)                      cmd[t] = 2;
                if (t == 16)                                           cmd[t] = 3;
                if (t == 2)                                            oeb[t] = 1'b0;
            end else if (s == 1) begin
                case (lfsr[9:8])
                    2'd0:    cmd[t] = 0;
                    2'd3:    cmd[t] = 2;
                    default: cmd[t] = 1;
                endcase
                if (lfsr[13:10] == 4'd0) cmd[t] = 3;
                if (lfsr[16:14] == 3'd0) oeb[t] = 1'b0;
            end else begin
                cmd[t] = (t % 3 == 1) ? 2 : 1;
                if (t == 9) cmd[t] = 3;
                if (t > 20) cmd[t] = 0;
            end
        end
    endtask

    task automatic run_scn();
        bit           drv;
        logic [W-1:0] word;
        logic [W-1:0] exp_en;
        string        tag;
        rst_n = 1'b0; rd_cmd = 1'b0; dsel_cmd = 1'b0; out_en = 1'b0; arr_rdata = '0;
        cfg_flow = flow; cfg_dual = dual;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        out_en = 1'b1;
        #5;
        check(dq_drv_en == '0, "R1", dq_drv_en, '0);
        for (int t = 0; t < NC; t++) begin
            @(negedge clk);
            rd_cmd    = (cmd[t] == 1) || (cmd[t] == 3);
            dsel_cmd  = (cmd[t] >= 2);
            arr_rdata = dat[t];
            out_en    = oeb[t];
            #5;
            expect_at(t, drv, word, tag);
            exp_en = (drv && oeb[t]) ? '1 : '0;
            check(dq_drv_en == exp_en, tag, dq_drv_en, exp_en);
            check(dq_drv_en == '0 || dq_drv_en == '1, "R10", dq_drv_en, exp_en);
            if (drv && oeb[t]) check(dq_out == word, tag, dq_out, word);
        end
    endtask

    initial begin
        for (int m = 0; m < 4; m++) begin
            flow = m[0];
            dual = m[1];
            for (int s = 0; s < 3; s++) begin
                sid = s;
                build(s);
                run_scn();
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1: actual still running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule